// File: doc/BRIEF.md
# Real-Mode Memory Operand Address Generator

This block turns the addressing fields of an already decoded operand byte into a 16-bit memory address. It takes the two-bit mode field, the three-bit register/memory selector, a 16-bit displacement and the current contents of the four pointer and index registers (BX, BP, SI, DI). From these it forms the sum of a base register, an index register and a displacement. When the operand names a register rather than memory, it reports that fact and the register number.

Alongside the address, the block gives a one-bit hint for the default segment. The hint shows the stack segment whenever BP takes part in the sum. The address logic is combinational. By default it is followed by an output register, so a result appears one cycle after a valid input. The consumer of the address does the segment arithmetic and the memory access.

Top module: `ea16_addr_gen`

## Requirements
- R1: When `rst_n` is low at a clock edge, the next cycle shows `out_valid`, `ea_addr`, `op_is_reg`, `op_reg_num` and `seg_is_stack` all at zero.
- R2: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high. The result outputs then reflect the inputs sampled at that edge.
- R3: With `mode` = 2'b10, the address is the selected sum plus the full 16-bit `disp`. The selector chooses the sum as follows: 0 = BX+SI, 1 = BX+DI, 2 = BP+SI, 3 = BP+DI, 4 = SI, 5 = DI, 6 = BP, 7 = BX.
- R4: With `mode` = 2'b01, only `disp[7:0]` is used. It is sign-extended to 16 bits before it is added, and `disp[15:8]` has no effect.
- R5: With `mode` = 2'b00 and a selector other than 6, the address is the selected sum alone, and `disp` has no effect.
- R6: With `mode` = 2'b00 and selector 6, the address equals `disp`. BP is not added, and `seg_is_stack` is 0.
- R7: With `mode` = 2'b11, `op_is_reg` is 1, `op_reg_num` equals the selector, `ea_addr` is 0 and `seg_is_stack` is 0. In every other mode, `op_is_reg` and `op_reg_num` are 0.
- R8: All additions wrap modulo 2^16, and any carry out of bit 15 is dropped.
- R9: `seg_is_stack` is 1 (stack segment) for selectors 2, 3 and 6 when `mode` is 2'b01 or 2'b10, and for selectors 2 and 3 when `mode` is 2'b00. In all other cases it is 0 (data segment).
- R10: After a clock edge with `in_valid` low, `out_valid` is 0 and the result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand fields and register values are valid |
| mode | input | 2 | Addressing mode field |
| rm_sel | input | 3 | Register/memory selector field |
| disp | input | 16 | Displacement; low byte only in mode 01 |
| reg_bx | input | 16 | Current BX value |
| reg_bp | input | 16 | Current BP value |
| reg_si | input | 16 | Current SI value |
| reg_di | input | 16 | Current DI value |
| out_valid | output | 1 | Result outputs are fresh |
| ea_addr | output | 16 | Effective address |
| op_is_reg | output | 1 | Operand is a register |
| op_reg_num | output | 3 | Register number when `op_is_reg` is 1 |
| seg_is_stack | output | 1 | Default segment hint: 1 = stack, 0 = data |

## Verification
Every cycle, the assertions check the one-cycle valid timing, the register-operand outputs, the direct-address case, the stack hint for BP-based modes and the holding of results while no input is valid. The bench's scenarios are the only place the numeric address sums are shown. These include the eight table entries, the negative and positive byte displacements, the ignored upper displacement byte in mode 01, the ignored displacement in mode 00 and the wrap past 16 bits.

// File: rtl/ea16_pkg.sv
// Shared types for the real-mode address generator.
// Assumes the standard two-bit mode encoding of the operand byte.
package ea16_pkg;
    typedef enum logic [1:0] {
        MODE_NODISP = 2'b00,
        MODE_DISP8  = 2'b01,
        MODE_DISP16 = 2'b10,
        MODE_REG    = 2'b11
    } ea_mode_e;

    localparam logic [2:0] RM_DIRECT = 3'd6;
endpackage

// File: rtl/ea16_base_sel.sv
// Chooses the base+index register sum for a selector value and reports
// whether BP is part of the sum. Assumes the caller handles register mode.
module ea16_base_sel
    import ea16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   mode,
    input  logic [2:0]   rm_sel,
    input  logic [W-1:0] reg_bx,
    input  logic [W-1:0] reg_bp,
    input  logic [W-1:0] reg_si,
    input  logic [W-1:0] reg_di,
    output logic [W-1:0] base_sum,
    output logic         uses_bp
);
    logic [W-1:0] first_reg;
    logic [W-1:0] second_reg;
    logic         direct;

    // Mode 00 with selector 6 drops the base register entirely.
    assign direct = (mode == MODE_NODISP) && (rm_sel == RM_DIRECT);

    // Pick the two operands of the register sum from the selector.
    always_comb begin
        first_reg  = '0;
        second_reg = '0;
        unique case (rm_sel)
            3'd0: begin first_reg = reg_bx; second_reg = reg_si; end
            3'd1: begin first_reg = reg_bx; second_reg = reg_di; end
            3'd2: begin first_reg = reg_bp; second_reg = reg_si; end
            3'd3: begin first_reg = reg_bp; second_reg = reg_di; end
            3'd4: first_reg = reg_si;
            3'd5: first_reg = reg_di;
            3'd6: first_reg = direct ? '0 : reg_bp;
            default: first_reg = reg_bx;
        endcase
    end

    // Wrap-around sum and stack-segment indication.
    always_comb begin
        base_sum = first_reg + second_reg;
        uses_bp  = (rm_sel == 3'd2) || (rm_sel == 3'd3) ||
                   ((rm_sel == RM_DIRECT) && !direct);
    end
endmodule

// File: rtl/ea16_disp_ext.sv
// Produces the displacement term for a mode: zero, sign-extended low
// byte, or the full word. Assumes register mode is masked downstream.
module ea16_disp_ext
    import ea16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   mode,
    input  logic [2:0]   rm_sel,
    input  logic [W-1:0] disp,
    output logic [W-1:0] disp_term
);
    localparam int BYTE_W = 8;

    // Select and extend the displacement according to the mode.
    always_comb begin
        unique case (mode)
            MODE_DISP8:  disp_term = {{(W-BYTE_W){disp[BYTE_W-1]}}, disp[BYTE_W-1:0]};
            MODE_DISP16: disp_term = disp;
            MODE_NODISP: disp_term = (rm_sel == RM_DIRECT) ? disp : '0;
            default:     disp_term = '0;
        endcase
    end
endmodule

// File: rtl/ea16_addr_gen.sv
// Top level: combines base sum and displacement, masks register-mode
// operands and, when REG_OUT is set, registers the result for one-cycle
// latency. Assumes all inputs are stable while in_valid is high.
module ea16_addr_gen
    import ea16_pkg::*;
#(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   mode,
    input  logic [2:0]   rm_sel,
    input  logic [W-1:0] disp,
    input  logic [W-1:0] reg_bx,
    input  logic [W-1:0] reg_bp,
    input  logic [W-1:0] reg_si,
    input  logic [W-1:0] reg_di,
    output logic         out_valid,
    output logic [W-1:0] ea_addr,
    output logic         op_is_reg,
    output logic [2:0]   op_reg_num,
    output logic         seg_is_stack
);
    logic [W-1:0] base_sum;
    logic         uses_bp;
    logic [W-1:0] disp_term;
    logic         nxt_is_reg;
    logic [W-1:0] nxt_ea;
    logic [2:0]   nxt_num;
    logic         nxt_stack;

    ea16_base_sel #(.W(W)) u_base (
        .mode     (mode),
        .rm_sel   (rm_sel),
        .reg_bx   (reg_bx),
        .reg_bp   (reg_bp),
        .reg_si   (reg_si),
        .reg_di   (reg_di),
        .base_sum (base_sum),
        .uses_bp  (uses_bp)
    );

    ea16_disp_ext #(.W(W)) u_disp (
        .mode      (mode),
        .rm_sel    (rm_sel),
        .disp      (disp),
        .disp_term (disp_term)
    );

    // Final sum, with register operands forcing the memory outputs to zero.
    always_comb begin
        nxt_is_reg = (mode == MODE_REG);
        nxt_ea     = nxt_is_reg ? '0 : (base_sum + disp_term);
        nxt_num    = nxt_is_reg ? rm_sel : 3'd0;
        nxt_stack  = nxt_is_reg ? 1'b0 : uses_bp;
    end

    generate
        if (REG_OUT) begin : g_reg
            // Capture results on valid input; hold them otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid    <= 1'b0;
                    ea_addr      <= '0;
                    op_is_reg    <= 1'b0;
                    op_reg_num   <= 3'd0;
                    seg_is_stack <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        ea_addr      <= nxt_ea;
                        op_is_reg    <= nxt_is_reg;
                        op_reg_num   <= nxt_num;
                        seg_is_stack <= nxt_stack;
                    end
                end
            end
        end else begin : g_comb
            // Pass-through variant with no latency.
            always_comb begin
                out_valid    = in_valid;
                ea_addr      = nxt_ea;
                op_is_reg    = nxt_is_reg;
                op_reg_num   = nxt_num;
                seg_is_stack = nxt_stack;
            end
        end
    endgenerate
endmodule

// File: rtl/ea16_addr_gen_chk.sv
// Property checker for the registered variant of the address generator.
// Observes ports only; attached by the bind below.
module ea16_addr_gen_chk #(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   mode,
    input logic [2:0]   rm_sel,
    input logic [W-1:0] disp,
    input logic         out_valid,
    input logic [W-1:0] ea_addr,
    input logic         op_is_reg,
    input logic [2:0]   op_reg_num,
    input logic         seg_is_stack
);
    generate
        if (REG_OUT) begin : g_props
            // R2
            valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);

            // R7
            reg_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode == 2'b11) |=>
                    (op_is_reg && op_reg_num == $past(rm_sel) &&
                     ea_addr == '0 && !seg_is_stack));

            // R6
            direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode == 2'b00 && rm_sel == 3'd6) |=>
                    (ea_addr == $past(disp) && !seg_is_stack && !op_is_reg));

            // R9
            stack_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (mode == 2'b01 || mode == 2'b10) && rm_sel == 3'd6) |=>
                    seg_is_stack);

            // R10
            hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && $stable(ea_addr) && $stable(op_is_reg) &&
                               $stable(op_reg_num) && $stable(seg_is_stack)));
        end
    endgenerate
endmodule

bind ea16_addr_gen ea16_addr_gen_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .mode         (mode),
    .rm_sel       (rm_sel),
    .disp         (disp),
    .out_valid    (out_valid),
    .ea_addr      (ea_addr),
    .op_is_reg    (op_is_reg),
    .op_reg_num   (op_reg_num),
    .seg_is_stack (seg_is_stack)
);

// File: tb/ea16_addr_gen_test.sv
module ea16_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [2:0]  rm_sel = 3'd0;
    logic [15:0] disp = 16'h0;
    logic [15:0] reg_bx = 16'h1000;
    logic [15:0] reg_bp = 16'h2000;
    logic [15:0] reg_si = 16'h0030;
    logic [15:0] reg_di = 16'h0400;
    logic        out_valid;
    logic [15:0] ea_addr;
    logic        op_is_reg;
    logic [2:0]  op_reg_num;
    logic        seg_is_stack;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ea16_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .rm_sel(rm_sel), .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp),
        .reg_si(reg_si), .reg_di(reg_di), .out_valid(out_valid),
        .ea_addr(ea_addr), .op_is_reg(op_is_reg), .op_reg_num(op_reg_num),
        .seg_is_stack(seg_is_stack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one operand for one cycle; outputs are sampled a cycle later.
    task automatic issue(input logic [1:0] m, input logic [2:0] r, input logic [15:0] d);
        @(negedge clk);
        mode = m; rm_sel = r; disp = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_mem(input string req, input logic [15:0] ea, input logic ss);
        check(req, {31'd0, out_valid}, 32'd1);
        check(req, {16'd0, ea_addr}, {16'd0, ea});
        check(req, {31'd0, seg_is_stack}, {31'd0, ss});
        check(req, {28'd0, op_is_reg, op_reg_num}, 32'd0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 outs", {12'd0, ea_addr, op_is_reg, op_reg_num}, 32'd0);
        check("R1 seg", {31'd0, seg_is_stack}, 32'd0);
    endtask

    task automatic test_table();
        logic [15:0] exp_ea [8] = '{16'h1035, 16'h1405, 16'h2035, 16'h2405,
                                    16'h0035, 16'h0405, 16'h2005, 16'h1005};
        logic        exp_ss [8] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
        for (int i = 0; i < 8; i++) begin
            issue(2'b10, 3'(i), 16'h0005);
            expect_mem("R3/R9 table", exp_ea[i], exp_ss[i]);
        end
    endtask

    task automatic test_disp8();
        issue(2'b01, 3'd7, 16'hAAF0);   // -16 from BX, upper byte ignored
        expect_mem("R4 negative", 16'h0FF0, 1'b0);
        issue(2'b01, 3'd4, 16'h127F);
        expect_mem("R4 positive", 16'h00AF, 1'b0);
        issue(2'b01, 3'd6, 16'h0001);
        expect_mem("R4/R9 bp", 16'h2001, 1'b1);
    endtask

    task automatic test_nodisp();
        issue(2'b00, 3'd0, 16'h5555);
        expect_mem("R5 bx+si", 16'h1030, 1'b0);
        issue(2'b00, 3'd3, 16'h5555);
        expect_mem("R5/R9 bp+di", 16'h2400, 1'b1);
    endtask

    task automatic test_direct();
        issue(2'b00, 3'd6, 16'h5555);
        expect_mem("R6 direct", 16'h5555, 1'b0);
    endtask

    task automatic test_register();
        issue(2'b11, 3'd5, 16'h1234);
        check("R7 is_reg", {31'd0, op_is_reg}, 32'd1);
        check("R7 num", {29'd0, op_reg_num}, 32'd5);
        check("R7 ea", {16'd0, ea_addr}, 32'd0);
        check("R7 seg", {31'd0, seg_is_stack}, 32'd0);
    endtask

    task automatic test_wrap();
        reg_bx = 16'hFFF0; reg_si = 16'h0020;
        issue(2'b10, 3'd0, 16'hFFFF);
        expect_mem("R8 wrap", 16'h000F, 1'b0);
        reg_bx = 16'h1000; reg_si = 16'h0030;
    endtask

    task automatic test_hold();
        issue(2'b10, 3'd1, 16'h0010);
        expect_mem("R2 result", 16'h1410, 1'b0);
        @(negedge clk);
        mode = 2'b11; rm_sel = 3'd2; disp = 16'hFFFF;
        @(negedge clk);
        check("R10 valid", {31'd0, out_valid}, 32'd0);
        check("R10 ea", {16'd0, ea_addr}, 32'h1410);
        check("R10 reg", {28'd0, op_is_reg, op_reg_num}, 32'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_table();
        test_disp8();
        test_nodisp();
        test_direct();
        test_register();
        test_wrap();
        test_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule